// File: doc/BRIEF.md
# Highest-Priority Pending LPI Table Scanner

This block finds the best pending message-signalled interrupt for one processor by walking two tables that live in memory. One is a pending bitmap with one bit per interrupt ID. The other is a configuration table with one byte per interrupt, and each byte holds an enable flag and a priority field. The block reaches memory through a simple byte-read port. It has at most one read in flight at any time.

A start pulse with the compare-mode input low begins a full scan. The scan clears the held winner to priority 0xFF. It then reads pending bytes in ascending order, starting at the byte that holds ID 8192. For every set bit it fetches that interrupt's configuration byte and keeps the better candidate. A start pulse with compare mode high fetches the configuration byte of one named interrupt and tests it against the held winner, without any rescan. In both cases the block pulses `done` once the held winner ID and priority are final. The winner is always a non-secure group 1 interrupt, so the block carries no group output.

Top module: `lpi_best_scan`

## Requirements
- R1: After reset `busy`, `done` and `rd_req` are 0 and `best_prio` is 0xFF.
- R2: A full scan reads pending bytes at `pend_base + n` exactly once each, in ascending n, for n from 1024 up to (2^(E+1))/8 − 1, where E is the capped ID-bits value. It reads no other pending address.
- R3: Bit i (0 = LSB) of pending byte n names interrupt ID n*8+i. That interrupt's configuration byte is read at `cfg_base + (ID − 8192)`.
- R4: A configuration byte whose enable bit (bit 0) is 0 is never taken as winner, in either mode.
- R5: The priority field is config bits 7:2, with bits 1:0 read as zero, giving P. When `sec_dis` is 1 the effective priority is P. Otherwise it is (P >> 1) | 0x80.
- R6: A candidate replaces the held winner when its effective priority is numerically lower. On equal priority it replaces the winner only when its ID is lower than or equal to the winner's ID. A full scan therefore keeps the lowest ID among equal priorities.
- R7: A full scan that finds no enabled pending interrupt ends with `best_prio` = 0xFF.
- R8: `id_bits` is capped to MAX_IDBITS (default 13) before the table size is computed. When 2^(E+1) ≤ 8192, a full scan makes no reads and ends with `best_prio` = 0xFF.
- R9: Compare mode makes exactly one configuration read and no pending read. It updates the held winner only as R6 allows. If `cmp_id` is below 8192 or not below 2^(E+1), it makes no read and leaves the winner unchanged.
- R10: At most one memory read is outstanding. A start while `busy` is ignored.
- R11: `busy` is 1 from the cycle after an accepted start through the `done` cycle. `done` is high for exactly one cycle, and `busy` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, sampled while idle |
| cmp_mode | input | 1 | 1 = single-interrupt compare, 0 = full scan |
| cmp_id | input | IDW | Interrupt ID used in compare mode |
| pend_base | input | AW | Byte address of the pending bitmap |
| cfg_base | input | AW | Byte address of configuration byte for ID 8192 |
| id_bits | input | 5 | Table size field; holds 2^(id_bits+1) IDs |
| sec_dis | input | 1 | 1 = security disabled, priority used directly |
| rd_req | output | 1 | One-cycle byte read request |
| rd_addr | output | AW | Byte address of the request |
| rd_rsp_vld | input | 1 | Read data valid |
| rd_rsp_data | input | 8 | Read data byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| best_id | output | IDW | Held winner ID |
| best_prio | output | 8 | Held winner priority, 0xFF when none |

## Verification
Properties check several rules on every cycle. No read request follows another before its response, and the latched operation settings stay constant while busy. Any real winner priority has a clear LSB and, after a secured scan, a set MSB. The held priority never rises during an operation, and `done` is a single-cycle pulse followed by idle. The bench scenarios alone can show the rest. These cover the exact pending address sequence and its size limit, the ID-to-config-address mapping, and the skipping of disabled entries. They also cover tie-breaking toward lower IDs, out-of-range compare IDs, and the discarding of a start issued mid-scan.

// File: rtl/lpi_scan_pkg.sv
package lpi_scan_pkg;
    localparam int FIRST_ID = 8192;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREQ,
        S_PWAIT,
        S_BITS,
        S_CREQ,
        S_CWAIT,
        S_DONE
    } scan_st_e;
endpackage

// File: rtl/lpi_range_calc.sv
module lpi_range_calc #(
    parameter int MAX_IDBITS = 13,
    parameter int IDW        = MAX_IDBITS + 1,
    parameter int BW         = IDW - 2
) (
    input  logic [4:0]     id_bits,
    input  logic [IDW-1:0] cmp_id,
    output logic [BW-1:0]  lim_byte,
    output logic           id_ok
);
    import lpi_scan_pkg::*;

    int eff;
    int size;

    always_comb begin
        eff      = (int'(id_bits) > MAX_IDBITS) ? MAX_IDBITS : int'(id_bits);
        size     = 1 << (eff + 1);
        lim_byte = BW'(size / 8);
        id_ok    = (int'(cmp_id) >= FIRST_ID) && (int'(cmp_id) < size);
    end
endmodule

// File: rtl/lpi_prio_eval.sv
module lpi_prio_eval #(
    parameter int IDW = 14
) (
    input  logic [7:0]     cfg,
    input  logic           sec_dis,
    input  logic [IDW-1:0] cand_id,
    input  logic [IDW-1:0] best_id,
    input  logic [7:0]     best_prio,
    output logic [7:0]     eff_prio,
    output logic           take
);
    always_comb begin
        if (sec_dis) eff_prio = {cfg[7:2], 2'b00};
        else         eff_prio = {1'b1, cfg[7:2], 1'b0};
        take = cfg[0] && ((eff_prio < best_prio) ||
                          ((eff_prio == best_prio) && (cand_id <= best_id)));
    end
endmodule

// File: rtl/lpi_best_scan.sv
module lpi_best_scan #(
    parameter int AW         = 32,
    parameter int MAX_IDBITS = 13,
    parameter int IDW        = MAX_IDBITS + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           cmp_mode,
    input  logic [IDW-1:0] cmp_id,
    input  logic [AW-1:0]  pend_base,
    input  logic [AW-1:0]  cfg_base,
    input  logic [4:0]     id_bits,
    input  logic           sec_dis,
    output logic           rd_req,
    output logic [AW-1:0]  rd_addr,
    input  logic           rd_rsp_vld,
    input  logic [7:0]     rd_rsp_data,
    output logic           busy,
    output logic           done,
    output logic [IDW-1:0] best_id,
    output logic [7:0]     best_prio
);
    import lpi_scan_pkg::*;

    localparam int BW         = IDW - 2;
    localparam int FIRST_BYTE = FIRST_ID / 8;

    typedef struct packed {
        scan_st_e       st;
        logic           cmp;
        logic           sec;
        logic [AW-1:0]  pbase;
        logic [AW-1:0]  cbase;
        logic [BW-1:0]  lim;
        logic [BW-1:0]  idx;
        logic [7:0]     pend;
        logic [2:0]     bitn;
        logic [IDW-1:0] cand;
        logic [IDW-1:0] best_id;
        logic [7:0]     best_prio;
    } scan_state_t;

    scan_state_t q, d;

    logic [BW-1:0] lim_w;
    logic          id_ok_w;
    logic [7:0]    eff_prio_w;
    logic          take_w;

    lpi_range_calc #(.MAX_IDBITS(MAX_IDBITS), .IDW(IDW), .BW(BW)) u_range (
        .id_bits  (id_bits),
        .cmp_id   (cmp_id),
        .lim_byte (lim_w),
        .id_ok    (id_ok_w)
    );

    lpi_prio_eval #(.IDW(IDW)) u_eval (
        .cfg       (rd_rsp_data),
        .sec_dis   (q.sec),
        .cand_id   (q.cand),
        .best_id   (q.best_id),
        .best_prio (q.best_prio),
        .eff_prio  (eff_prio_w),
        .take      (take_w)
    );

    // step to next pending bit or next pending byte
    scan_st_e      adv_st;
    logic [BW-1:0] adv_idx;
    logic [2:0]    adv_bit;

    always_comb begin
        adv_idx = q.idx;
        adv_bit = q.bitn + 3'd1;
        adv_st  = S_BITS;
        if (q.bitn == 3'd7) begin
            adv_idx = q.idx + BW'(1);
            adv_st  = (adv_idx >= q.lim) ? S_DONE : S_PREQ;
        end
    end

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.cmp   = cmp_mode;
                    d.sec   = sec_dis;
                    d.pbase = pend_base;
                    d.cbase = cfg_base;
                    d.lim   = lim_w;
                    if (cmp_mode) begin
                        d.cand = cmp_id;
                        d.st   = id_ok_w ? S_CREQ : S_DONE;
                    end else begin
                        d.best_prio = 8'hFF;
                        d.best_id   = '1;
                        d.idx       = BW'(FIRST_BYTE);
                        d.st        = (BW'(FIRST_BYTE) >= lim_w) ? S_DONE : S_PREQ;
                    end
                end
            end
            S_PREQ:  d.st = S_PWAIT;
            S_PWAIT: begin
                if (rd_rsp_vld) begin
                    d.pend = rd_rsp_data;
                    d.bitn = 3'd0;
                    d.st   = S_BITS;
                end
            end
            S_BITS: begin
                if (q.pend[q.bitn]) begin
                    d.cand = {q.idx[IDW-4:0], q.bitn};
                    d.st   = S_CREQ;
                end else begin
                    d.idx  = adv_idx;
                    d.bitn = adv_bit;
                    d.st   = adv_st;
                end
            end
            S_CREQ:  d.st = S_CWAIT;
            S_CWAIT: begin
                if (rd_rsp_vld) begin
                    if (take_w) begin
                        d.best_prio = eff_prio_w;
                        d.best_id   = q.cand;
                    end
                    if (q.cmp) begin
                        d.st = S_DONE;
                    end else begin
                        d.idx  = adv_idx;
                        d.bitn = adv_bit;
                        d.st   = adv_st;
                    end
                end
            end
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= S_IDLE;
            q.best_prio <= 8'hFF;
            q.best_id   <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_req  = (q.st == S_PREQ) || (q.st == S_CREQ);
        rd_addr = (q.st == S_PREQ) ? (q.pbase + AW'(q.idx))
                                   : (q.cbase + AW'(q.cand) - AW'(FIRST_ID));
    end

    assign busy      = (q.st != S_IDLE);
    assign done      = (q.st == S_DONE);
    assign best_id   = q.best_id;
    assign best_prio = q.best_prio;

    // R10: a request is never followed at once by another one
    p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R10: latched settings do not move while an operation runs
    p_cfg_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE) |=> ($stable(q.pbase) && $stable(q.cmp) && $stable(q.lim)));

    // R5: any real priority has a clear LSB
    p_prio_lsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (best_prio != 8'hFF) |-> !best_prio[0]);

    // R5: secured full scan yields an MSB-set priority
    p_sec_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !q.sec && !q.cmp && best_prio != 8'hFF) |-> best_prio[7]);

    // R6: the held priority never worsens during an operation
    p_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != S_IDLE) |=> (best_prio <= $past(best_prio)));

    // R11: done lasts one cycle and is followed by idle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: tb/lpi_best_scan_bench.sv
module lpi_best_scan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 32;
    localparam int MAXB = 13;
    localparam int IDW = MAXB + 1;
    localparam int PB  = 32'h0001_0000;
    localparam int CB  = 32'h0004_0000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           cmp_mode = 1'b0;
    logic [IDW-1:0] cmp_id = '0;
    logic [AW-1:0]  pend_base = '0;
    logic [AW-1:0]  cfg_base = '0;
    logic [4:0]     id_bits = '0;
    logic           sec_dis = 1'b0;
    logic           rd_req;
    logic [AW-1:0]  rd_addr;
    logic           rd_rsp_vld = 1'b0;
    logic [7:0]     rd_rsp_data = '0;
    logic           busy, done;
    logic [IDW-1:0] best_id;
    logic [7:0]     best_prio;

    lpi_best_scan #(.AW(AW), .MAX_IDBITS(MAXB), .IDW(IDW)) u_lpi_best_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_mode(cmp_mode),
        .cmp_id(cmp_id), .pend_base(pend_base), .cfg_base(cfg_base),
        .id_bits(id_bits), .sec_dis(sec_dis), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_rsp_vld(rd_rsp_vld), .rd_rsp_data(rd_rsp_data),
        .busy(busy), .done(done), .best_id(best_id), .best_prio(best_prio)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int done_cnt = 0;
    int overlap_err = 0;
    int lat_cnt = 0;
    logic [AW-1:0] lat_addr = '0;
    int unsigned rd_log[$];
    logic [7:0] mem [int unsigned];

    function automatic logic [7:0] rdmem(input int unsigned a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    // memory model: fixed latency, logs every request
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (done) done_cnt <= done_cnt + 1;
        rd_rsp_vld <= 1'b0;
        if (lat_cnt == 1) begin
            rd_rsp_vld  <= 1'b1;
            rd_rsp_data <= rdmem(lat_addr);
        end
        if (lat_cnt != 0) lat_cnt <= lat_cnt - 1;
        if (rd_req) begin
            if (lat_cnt != 0) overlap_err <= overlap_err + 1;
            lat_cnt  <= 2;
            lat_addr <= rd_addr;
            rd_log.push_back(rd_addr);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void set_pend(input int id);
        int unsigned a = PB + id / 8;
        mem[a] = rdmem(a) | (8'h01 << (id % 8));
    endfunction

    function automatic void set_cfg(input int id, input logic [7:0] v);
        mem[CB + id - 8192] = v;
    endfunction

    // expected result of a full scan, from the requirement text
    task automatic model(input int idb, input bit sd, output int eid, output int ep);
        int e = (idb > MAXB) ? MAXB : idb;
        int lim = (1 << (e + 1)) / 8;
        eid = (1 << IDW) - 1;
        ep = 255;
        for (int n = 1024; n < lim; n++) begin
            logic [7:0] pb = rdmem(PB + n);
            for (int b = 0; b < 8; b++) begin
                if (pb[b]) begin
                    int id = n * 8 + b;
                    logic [7:0] c = rdmem(CB + id - 8192);
                    int p = sd ? {c[7:2], 2'b00} : {1'b1, c[7:2], 1'b0};
                    if (c[0] && (p < ep || (p == ep && id <= eid))) begin
                        ep = p; eid = id;
                    end
                end
            end
        end
    endtask

    function automatic int pend_reads();
        int k = 0;
        foreach (rd_log[i]) if (rd_log[i] >= PB && rd_log[i] < PB + 4096) k++;
        return k;
    endfunction

    int post_busy;
    int start_busy;

    task automatic run_op(input bit cm, input int cid, input int idb, input bit sd);
        int w = 0;
        @(negedge clk);
        rd_log.delete();
        cmp_mode = cm; cmp_id = IDW'(cid); pend_base = PB; cfg_base = CB;
        id_bits = 5'(idb); sec_dis = sd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        start_busy = busy;
        while (!done && w < 20000) begin
            @(negedge clk);
            w++;
        end
        if (!done) chk("R11 done timeout", 0, 1);
        @(negedge clk);
        post_busy = busy;
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 rd_req", rd_req, 0);
        chk("R1 best_prio", best_prio, 8'hFF);
    endtask

    task automatic t_empty();
        mem.delete();
        run_op(1'b0, 0, 13, 1'b1);
        chk("R7 empty prio", best_prio, 8'hFF);
        chk("R2 read count", rd_log.size(), 1024);
        chk("R2 first addr", rd_log[0], PB + 1024);
        chk("R2 last addr", rd_log[rd_log.size()-1], PB + 2047);
        chk("R11 busy after start", start_busy, 1);
        chk("R11 idle after done", post_busy, 0);
    endtask

    task automatic t_mixed();
        int eid, ep;
        bit seen;
        set_pend(8200);  set_cfg(8200, 8'h41);
        set_pend(9000);  set_cfg(9000, 8'h21);
        set_pend(9001);  set_cfg(9001, 8'h10);
        set_pend(12000); set_cfg(12000, 8'h21);
        run_op(1'b0, 0, 13, 1'b1);
        model(13, 1'b1, eid, ep);
        chk("R6 winner id", best_id, 9000);
        chk("R6 model id", best_id, eid);
        chk("R5 direct prio", best_prio, 8'h20);
        chk("R4 disabled 9001 skipped", (best_id == 9001) ? 1 : 0, 0);
        seen = 0;
        foreach (rd_log[i]) if (rd_log[i] == CB + 808) seen = 1;
        chk("R3 config addr of 9000", seen, 1);
        chk("R3 cfg reads", rd_log.size() - pend_reads(), 4);
        run_op(1'b0, 0, 13, 1'b0);
        chk("R5 secured prio", best_prio, 8'h90);
        chk("R5 model prio", best_prio, ep == 8'h20 ? 8'h90 : 0);
    endtask

    task automatic t_cap();
        run_op(1'b0, 0, 12, 1'b1);
        chk("R8 no reads small table", rd_log.size(), 0);
        chk("R8 small table prio", best_prio, 8'hFF);
        set_pend(16383); set_cfg(16383, 8'h05);
        run_op(1'b0, 0, 31, 1'b1);
        chk("R8 capped read count", pend_reads(), 1024);
        chk("R3 top id", best_id, 16383);
        chk("R3 top prio", best_prio, 8'h04);
        mem.delete(PB + 2047);
    endtask

    task automatic t_compare();
        run_op(1'b0, 0, 13, 1'b1);
        chk("R6 base winner", best_id, 9000);
        set_cfg(8500, 8'h1D);
        run_op(1'b1, 8500, 13, 1'b1);
        chk("R9 one read", rd_log.size(), 1);
        chk("R9 no pending read", pend_reads(), 0);
        chk("R9 addr", rd_log[0], CB + 308);
        chk("R9 better id", best_id, 8500);
        chk("R9 better prio", best_prio, 8'h1C);
        set_cfg(8400, 8'h1D);
        run_op(1'b1, 8400, 13, 1'b1);
        chk("R6 tie lower id", best_id, 8400);
        set_cfg(8600, 8'h1D);
        run_op(1'b1, 8600, 13, 1'b1);
        chk("R6 tie higher id kept", best_id, 8400);
        set_cfg(8450, 8'h1C);
        run_op(1'b1, 8450, 13, 1'b1);
        chk("R4 disabled compare", best_id, 8400);
        run_op(1'b1, 100, 13, 1'b1);
        chk("R9 low id no read", rd_log.size(), 0);
        chk("R9 low id unchanged", best_id, 8400);
        run_op(1'b1, 9000, 12, 1'b1);
        chk("R9 oversize no read", rd_log.size(), 0);
        chk("R9 oversize prio", best_prio, 8'h1C);
    endtask

    task automatic t_busy_start();
        int d0;
        int w = 0;
        @(negedge clk);
        d0 = done_cnt;
        rd_log.delete();
        cmp_mode = 1'b0; pend_base = PB; cfg_base = CB; id_bits = 13; sec_dis = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        cmp_mode = 1'b1; cmp_id = IDW'(8500); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && w < 20000) begin
            @(negedge clk);
            w++;
        end
        repeat (3) @(negedge clk);
        chk("R10 start ignored id", best_id, 9000);
        chk("R10 start ignored prio", best_prio, 8'h20);
        chk("R11 single done", done_cnt - d0, 1);
        chk("R10 no overlap", overlap_err, 0);
        chk("R2 pending reads once", pend_reads(), 1024);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_mixed();
        t_cap();
        t_compare();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        chk("watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule